// File: doc/BRIEF.md
# Hardware Interrupt Entry Sequencer

This block takes a running program off the processor when a device with more urgency asks for it, and it does the whole hand-over in hardware. It watches a small set of interrupt sources. Each source has an enable bit, a ready bit, a priority level and an 8-bit vector. When an instruction completes, the block compares the best requesting source with the priority held in the current status word. If the source is strictly more urgent, the block leaves the normal next-instruction path and steps through extra control states.

Those states push the status word and then the program counter onto a downward-growing stack in memory. They then read the handler address from a vector table in memory. Finally they present the new program counter, the new status word (now carrying the winner's priority) and the new stack pointer, together with a one-cycle completion pulse. Every memory access uses a request/ready handshake. The surrounding core loads the three new values when it sees the pulse. It stalls while the busy flag is high.

Top module: `irq_entry_seq`

## Requirements
- R1: A source counts as requesting only when its enable bit and its ready bit are both 1; an enabled source that is not ready, or a ready source that is disabled, never starts a switch.
- R2: The running priority is `cur_psr[10:8]`. A switch starts only when the winning source's priority is strictly greater than that field; an equal or lower priority leaves `busy` low and `switch_done` low.
- R3: The take decision is sampled only in a cycle where the block is idle and `instr_done` is 1. A request held across cycles with `instr_done` at 0 causes no activity, and it is taken at the next cycle with `instr_done` at 1.
- R4: Among requesting sources the highest priority wins; on equal priority the lower source index wins.
- R5: The status word captured at the boundary is written to address `cur_sp-2` first. The program counter is then written to `cur_sp-4`. `new_sp` becomes `cur_sp-4`.
- R6: The handler address is read from `TABLE_BASE + 2*vector` (default base 0x0200) and is delivered on `new_pc`.
- R7: `new_psr` equals the captured status word with bits [10:8] replaced by the winning source's priority; all other bits are unchanged.
- R8: Each memory access keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until `mem_ready` is 1. `busy` rises in the cycle after the boundary and stays high for three accesses. That is 3 cycles when `mem_ready` answers at once, and 3*(1+w) cycles with w wait cycles per access.
- R9: `switch_done` is a one-cycle pulse in the cycle after the table read completes. `new_pc`, `new_psr` and `new_sp` hold their values until the next switch. After reset, `busy`, `switch_done`, `mem_req` and all three new-value outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_en | input | NSRC | Per-source enable bit |
| src_rdy | input | NSRC | Per-source ready bit |
| src_prio | input | NSRC*PRIO_W | Packed per-source priority, source i at bits [i*PRIO_W +: PRIO_W] |
| src_vec | input | NSRC*VEC_W | Packed per-source vector, source i at bits [i*VEC_W +: VEC_W] |
| instr_done | input | 1 | High in a cycle that ends an instruction |
| cur_pc | input | WORD_W | Program counter of the running program |
| cur_psr | input | WORD_W | Status word of the running program, priority in [10:8] |
| cur_sp | input | WORD_W | Current stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | WORD_W | Byte address of the word accessed |
| mem_wdata | output | WORD_W | Write data |
| mem_rdata | input | WORD_W | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes in this cycle |
| new_pc | output | WORD_W | Handler start address |
| new_psr | output | WORD_W | Status word for the handler |
| new_sp | output | WORD_W | Stack pointer after the two pushes |
| busy | output | 1 | Sequencer is performing a switch |
| switch_done | output | 1 | One-cycle pulse: new values are valid |

## Verification
The bench builds the block with its defaults: four sources, 3-bit priorities, 8-bit vectors and a table base of 0x0200. Four sources are enough to set up a two-way tie, a winner that beats a lower-index rival, and disabled or not-ready contenders in the same run. The 3-bit priority lets the running level sit at the equal, lower and higher sides of a request. A behavioural memory answers either at once or after two wait cycles, which brings the handshake hold and the longer busy window within reach.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PUSH_PSR = 2'd1,
        ST_PUSH_PC  = 2'd2,
        ST_READ_VEC = 2'd3
    } seq_state_e;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NSRC   = 4,
    parameter int PRIO_W = 3,
    parameter int VEC_W  = 8,
    parameter int IDX_W  = 2
) (
    input  logic [NSRC-1:0]        src_en,
    input  logic [NSRC-1:0]        src_rdy,
    input  logic [NSRC*PRIO_W-1:0] src_prio,
    input  logic [NSRC*VEC_W-1:0]  src_vec,
    output logic                   win_valid,
    output logic [IDX_W-1:0]       win_idx,
    output logic [PRIO_W-1:0]      win_prio,
    output logic [VEC_W-1:0]       win_vec,
    output logic [NSRC-1:0]        grant
);
    logic [NSRC-1:0] active;

    // R1: a source requests only with enable and ready both set
    assign active = src_en & src_rdy;

    // R4: scan upward, replace only on strictly higher priority,
    // so the lowest index keeps a tie
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_prio  = '0;
        win_vec   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (active[i] && (!win_valid || src_prio[i*PRIO_W +: PRIO_W] > win_prio)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                win_prio  = src_prio[i*PRIO_W +: PRIO_W];
                win_vec   = src_vec[i*VEC_W +: VEC_W];
            end
        end
        grant = '0;
        if (win_valid) grant[win_idx] = 1'b1;
    end
endmodule

// File: rtl/irq_addr_calc.sv
module irq_addr_calc #(
    parameter int              WORD_W     = 16,
    parameter int              VEC_W      = 8,
    parameter logic [WORD_W-1:0] TABLE_BASE = 16'h0200
) (
    input  logic [WORD_W-1:0] sp_base,
    input  logic [VEC_W-1:0]  vec,
    output logic [WORD_W-1:0] psr_slot,
    output logic [WORD_W-1:0] pc_slot,
    output logic [WORD_W-1:0] table_addr
);
    localparam logic [WORD_W-1:0] WORD_BYTES = WORD_W'(2);

    // R5: pre-decrement by one word before each push
    assign psr_slot   = sp_base - WORD_BYTES;
    assign pc_slot    = psr_slot - WORD_BYTES;
    // R6: table entries are one word apart
    assign table_addr = TABLE_BASE + WORD_W'({vec, 1'b0});
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int                NSRC       = 4,
    parameter int                PRIO_W     = 3,
    parameter int                VEC_W      = 8,
    parameter int                WORD_W     = 16,
    parameter int                PRIO_LSB   = 8,
    parameter logic [WORD_W-1:0] TABLE_BASE = 16'h0200
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSRC-1:0]          src_en,
    input  logic [NSRC-1:0]          src_rdy,
    input  logic [NSRC*PRIO_W-1:0]   src_prio,
    input  logic [NSRC*VEC_W-1:0]    src_vec,
    input  logic                     instr_done,
    input  logic [WORD_W-1:0]        cur_pc,
    input  logic [WORD_W-1:0]        cur_psr,
    input  logic [WORD_W-1:0]        cur_sp,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [WORD_W-1:0]        mem_addr,
    output logic [WORD_W-1:0]        mem_wdata,
    input  logic [WORD_W-1:0]        mem_rdata,
    input  logic                     mem_ready,
    output logic [WORD_W-1:0]        new_pc,
    output logic [WORD_W-1:0]        new_psr,
    output logic [WORD_W-1:0]        new_sp,
    output logic                     busy,
    output logic                     switch_done
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    typedef struct packed {
        seq_state_e        state;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] psr;
        logic [WORD_W-1:0] sp;
        logic [VEC_W-1:0]  vec;
        logic [PRIO_W-1:0] prio;
        logic [WORD_W-1:0] new_pc;
        logic [WORD_W-1:0] new_psr;
        logic [WORD_W-1:0] new_sp;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic                win_valid;
    logic [IDX_W-1:0]    win_idx;
    logic [PRIO_W-1:0]   win_prio;
    logic [VEC_W-1:0]    win_vec;
    logic [NSRC-1:0]     grant;
    logic [PRIO_W-1:0]   run_prio;
    logic                take;
    logic [WORD_W-1:0]   psr_slot, pc_slot, table_addr;
    logic [WORD_W-1:0]   psr_upd;

    irq_prio_pick #(
        .NSRC(NSRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .IDX_W(IDX_W)
    ) u_pick (
        .src_en(src_en), .src_rdy(src_rdy), .src_prio(src_prio), .src_vec(src_vec),
        .win_valid(win_valid), .win_idx(win_idx), .win_prio(win_prio),
        .win_vec(win_vec), .grant(grant)
    );

    irq_addr_calc #(
        .WORD_W(WORD_W), .VEC_W(VEC_W), .TABLE_BASE(TABLE_BASE)
    ) u_addr (
        .sp_base(r_q.sp), .vec(r_q.vec),
        .psr_slot(psr_slot), .pc_slot(pc_slot), .table_addr(table_addr)
    );

    // R2: strictly higher than the running level
    assign run_prio = cur_psr[PRIO_LSB +: PRIO_W];
    assign take     = win_valid && (win_prio > run_prio);

    // R7: swap in the winner's level, keep every other bit
    always_comb begin
        psr_upd = r_q.psr;
        psr_upd[PRIO_LSB +: PRIO_W] = r_q.prio;
    end

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (r_q.state)
            ST_IDLE: begin
                // R3: microbranch only at an instruction boundary
                if (instr_done && take) begin
                    r_d.state = ST_PUSH_PSR;
                    r_d.pc    = cur_pc;
                    r_d.psr   = cur_psr;
                    r_d.sp    = cur_sp;
                    r_d.vec   = win_vec;
                    r_d.prio  = win_prio;
                end
            end
            ST_PUSH_PSR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = psr_slot;
                mem_wdata = r_q.psr;
                if (mem_ready) r_d.state = ST_PUSH_PC;
            end
            ST_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = pc_slot;
                mem_wdata = r_q.pc;
                if (mem_ready) r_d.state = ST_READ_VEC;
            end
            ST_READ_VEC: begin
                mem_req  = 1'b1;
                mem_addr = table_addr;
                if (mem_ready) begin
                    r_d.state   = ST_IDLE;
                    r_d.new_pc  = mem_rdata;
                    r_d.new_psr = psr_upd;
                    r_d.new_sp  = pc_slot;
                    r_d.done    = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.state != ST_IDLE);
    assign switch_done = r_q.done;
    assign new_pc      = r_q.new_pc;
    assign new_psr     = r_q.new_psr;
    assign new_sp      = r_q.new_sp;

    // R1
    win_src_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (src_en[win_idx] && src_rdy[win_idx]));

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3
    no_mid_instr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !instr_done) |=> !busy);

    // R2
    no_equal_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && win_valid && win_prio <= run_prio) |=> !busy);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_wdata)));

    // R9
    done_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_done |-> (!busy && $past(mem_req && !mem_we && mem_ready)));

    // R7
    new_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_done |-> (new_psr[PRIO_LSB +: PRIO_W] == r_q.prio));
endmodule

// File: tb/irq_entry_seq_test.sv
`timescale 1ns/1ps
module irq_entry_seq_test;
    localparam int NSRC = 4;
    localparam int PW   = 3;
    localparam int VW   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  src_en = '0, src_rdy = '0;
    logic [PW-1:0]    prio_a [NSRC];
    logic [VW-1:0]    vec_a  [NSRC];
    logic [NSRC*PW-1:0] src_prio;
    logic [NSRC*VW-1:0] src_vec;
    logic             instr_done = 1'b0;
    logic [15:0]      cur_pc = 16'h3000, cur_psr = 16'h0204, cur_sp = 16'h0700;
    logic             mem_req, mem_we, mem_ready;
    logic [15:0]      mem_addr, mem_wdata, mem_rdata;
    logic [15:0]      new_pc, new_psr, new_sp;
    logic             busy, switch_done;

    logic [15:0]      mem [0:1023];
    int               wait_cfg = 0;
    int               wcnt = 0;
    int               checks = 0;
    int               fails = 0;
    bit               finished = 1'b0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NSRC; i++) begin
            src_prio[i*PW +: PW] = prio_a[i];
            src_vec[i*VW +: VW]  = vec_a[i];
        end
    end

    assign mem_ready = mem_req && (wcnt == wait_cfg);
    assign mem_rdata = mem[mem_addr[10:1]];

    always @(posedge clk) begin
        if (mem_req && !mem_ready) wcnt <= wcnt + 1;
        else wcnt <= 0;
        if (mem_req && mem_ready && mem_we) mem[mem_addr[10:1]] <= mem_wdata;
    end

    irq_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .src_rdy(src_rdy),
        .src_prio(src_prio), .src_vec(src_vec), .instr_done(instr_done),
        .cur_pc(cur_pc), .cur_psr(cur_psr), .cur_sp(cur_sp),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .new_pc(new_pc), .new_psr(new_psr), .new_sp(new_sp),
        .busy(busy), .switch_done(switch_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] handler_of(input int v);
        return 16'h4000 + 16'(v * 16);
    endfunction

    task automatic clear_src();
        src_en = '0;
        src_rdy = '0;
        for (int i = 0; i < NSRC; i++) begin
            prio_a[i] = '0;
            vec_a[i]  = '0;
        end
    endtask

    // pulse a boundary and expect no switch
    task automatic expect_none(input string req);
        logic [15:0] old_pc;
        old_pc = new_pc;
        @(negedge clk) instr_done = 1'b1;
        @(negedge clk) instr_done = 1'b0;
        for (int c = 0; c < 5; c++) begin
            check(!busy && !switch_done && !mem_req, req, "no switch", {busy, switch_done}, 0);
            @(negedge clk);
        end
        check(new_pc == old_pc, req, "new_pc untouched", new_pc, old_pc);
    endtask

    // pulse a boundary and expect a full switch for vector v at level p
    task automatic expect_switch(input string req, input int v, input int p, input int waits);
        int cnt;
        logic [15:0] exp_psr;
        wait_cfg = waits;
        @(negedge clk) instr_done = 1'b1;
        @(negedge clk) instr_done = 1'b0;
        cnt = 0;
        while (busy && cnt < 100) begin
            cnt++;
            @(negedge clk);
        end
        check(cnt == 3 * (1 + waits), "R8", "busy length", cnt, 3 * (1 + waits));
        check(switch_done == 1'b1, "R9", "done pulse", switch_done, 1);
        check(new_pc == handler_of(v), req, "R6 handler pc", new_pc, handler_of(v));
        exp_psr = (cur_psr & 16'hF8FF) | 16'(p << 8);
        check(new_psr == exp_psr, "R7", "new psr", new_psr, exp_psr);
        check(new_sp == cur_sp - 16'd4, "R5", "new sp", new_sp, cur_sp - 16'd4);
        check(mem[(cur_sp - 16'd2) >> 1] == cur_psr, "R5", "psr slot", mem[(cur_sp - 16'd2) >> 1], cur_psr);
        check(mem[(cur_sp - 16'd4) >> 1] == cur_pc, "R5", "pc slot", mem[(cur_sp - 16'd4) >> 1], cur_pc);
        @(negedge clk);
        check(switch_done == 1'b0, "R9", "pulse one cycle", switch_done, 0);
        check(new_pc == handler_of(v), "R9", "new_pc held", new_pc, handler_of(v));
        wait_cfg = 0;
    endtask

    task automatic t_reset();
        check(!busy && !switch_done && !mem_req, "R9", "reset idle", {busy, switch_done, mem_req}, 0);
        check(new_pc == 0 && new_psr == 0 && new_sp == 0, "R9", "reset values", new_pc, 0);
    endtask

    task automatic t_gate_bits();
        clear_src();
        src_en[0] = 1'b1; prio_a[0] = 3'd7; vec_a[0] = 8'h10;   // enabled, not ready
        src_rdy[1] = 1'b1; prio_a[1] = 3'd7; vec_a[1] = 8'h11;  // ready, disabled
        expect_none("R1");
    endtask

    task automatic t_equal_lower();
        clear_src();
        src_en[2] = 1'b1; src_rdy[2] = 1'b1; prio_a[2] = 3'd2; vec_a[2] = 8'h20;
        expect_none("R2 equal");
        prio_a[2] = 3'd1;
        expect_none("R2 lower");
    endtask

    task automatic t_single();
        clear_src();
        src_en[3] = 1'b1; src_rdy[3] = 1'b1; prio_a[3] = 3'd3; vec_a[3] = 8'h05;
        expect_switch("R2 higher", 8'h05, 3, 0);
    endtask

    task automatic t_mid_instr();
        clear_src();
        cur_pc = 16'h3456; cur_sp = 16'h0680;
        src_en[0] = 1'b1; src_rdy[0] = 1'b1; prio_a[0] = 3'd5; vec_a[0] = 8'hFF;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check(!busy && !mem_req, "R3", "held mid instruction", busy, 0);
        end
        expect_switch("R3", 8'hFF, 5, 0);
    endtask

    task automatic t_tie();
        clear_src();
        cur_psr = 16'h8001;  // running level 0
        src_en = 4'b1010; src_rdy = 4'b1010;
        prio_a[1] = 3'd6; vec_a[1] = 8'h31;
        prio_a[3] = 3'd6; vec_a[3] = 8'h33;
        expect_switch("R4 tie", 8'h31, 6, 0);
    endtask

    task automatic t_highest();
        clear_src();
        cur_psr = 16'h0100;
        src_en = 4'b1111; src_rdy = 4'b1101;
        prio_a[0] = 3'd3; vec_a[0] = 8'h40;
        prio_a[1] = 3'd7; vec_a[1] = 8'h41;  // not ready
        prio_a[2] = 3'd7; vec_a[2] = 8'h42;
        prio_a[3] = 3'd4; vec_a[3] = 8'h43;
        expect_switch("R4 highest", 8'h42, 7, 0);
    endtask

    task automatic t_wait_states();
        clear_src();
        cur_pc = 16'h1234; cur_psr = 16'h0377; cur_sp = 16'h0600;
        src_en[2] = 1'b1; src_rdy[2] = 1'b1; prio_a[2] = 3'd4; vec_a[2] = 8'h80;
        expect_switch("R8 waits", 8'h80, 4, 2);
    endtask

    initial begin
        clear_src();
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
        for (int v = 0; v < 256; v++) mem[256 + v] = handler_of(v);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_gate_bits();
        t_equal_lower();
        t_single();
        t_mid_instr();
        t_tie();
        t_highest();
        t_wait_states();
        finished = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !finished; c++) @(negedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule